// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block turns single-word requests from a clocked host into correctly timed access cycles on an asynchronous static RAM of one mega-word by sixteen bits. The host presents a request strobe together with a direction flag, a word address, write data and one enable per byte lane. The controller acknowledges the request in the cycle in which it takes it. It then runs the memory through a fixed sequence of phases. For a read, the word comes back on a separate bus together with a one-cycle valid pulse.

All memory timing minimums are given in nanoseconds as parameters. A ceiling division by the clock-period parameter turns them into cycle counts, so the same code fits any system clock. Writes always run as write-enable-controlled cycles, and output enable stays high during them. When no request is pending, the controller releases chip enable and all byte-lane enables, which puts the memory in standby. The next access from standby waits out the power-up time. An access that follows directly keeps the chip selected and skips that wait.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While idle and after reset, chip enable (`sram_ce_n`), both lane enables, write enable and output enable are all high and the bus driver is off; chip select `sram_cs` is always high.
- R2: `req_ack` is a one-cycle pulse in the cycle a request is taken, and each request gets exactly one acknowledge.
- R3: An access starting from standby keeps chip enable low with write and output enable high for ceil(T_PU_NS/CLK_NS) cycles (7 at the defaults) before either strobe falls.
- R4: Write enable stays low for max(ceil(T_WP/CLK), ceil(T_DS/CLK), ceil(T_AW/CLK), ceil(T_WC/CLK)-2) cycles (6 at the defaults). Address and data do not change while it is low, and it is low only with chip enable low.
- R5: Output enable and write enable are never low together. The bus driver is on during every write-enable-low cycle and never while output enable is low.
- R6: A read holds output enable low for max(ceil(T_AA/CLK), ceil(T_OE/CLK), ceil(T_RC/CLK)-2) cycles (7 at the defaults) with write enable high.
- R7: `rd_valid` is high for exactly one cycle: the first cycle after output enable rises. `rd_data` then holds the word sampled on the last output-enable-low cycle.
- R8: `sram_bl_n[i]` is the inverse of `req_be[i]` during an access, where lane 1 is bits 15:8 and lane 0 is bits 7:0. A write changes only the enabled lanes. A read returns zero in the disabled lanes.
- R9: Between two back-to-back accesses, the address holds through the write-enable rising cycle and the cycle after it. The gap from one strobe rising to the next strobe falling is 3 cycles (1 recovery, ceil(T_TURN/CLK)=1 turnaround, 1 setup), and chip enable stays low throughout.
- R10: When no request is pending at the end of the turnaround, the controller returns to standby, and the next access again pays the power-up wait.
- R11: A request with both lane enables low runs its full cycle with both lane enables high. It changes no memory word, and a read returns zero.
- R12: All 20 address bits reach the memory, so walking-one addresses and address zero select distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 1 = upper byte |
| req_ack | output | 1 | Request taken (one cycle) |
| rd_data | output | 16 | Read result, disabled lanes zero |
| rd_valid | output | 1 | Read result valid (one cycle) |
| sram_addr | output | 20 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_cs | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bl_n | output | 2 | Lane enables, active low, bit 1 = upper byte |
| sram_dq | inout | 16 | Memory data bus |
| sram_dq_oe | output | 1 | Controller drives `sram_dq` |

## Verification
The bench sweeps every lane-enable combination on writes and on reads over one word. This separates merge errors, swapped lanes and missing read masks. Walking-one addresses over all 20 bits, plus address zero and the top address, expose stuck or shorted address bits. Isolated accesses alternate with back-to-back write, read and mixed bursts, so that the standby power-up wait can be told apart from the short warm gap. A cycle-level memory model stores only what the observed write-enable pulses write, and each phase length is measured at the pins.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } ctl_state_e;

    // Control levels that one phase places on the memory pins
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lanes_on;
        logic drive;
    } pin_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int wr_pulse_cyc(input int clk_ns, input int wp, input int ds,
                                        input int aw, input int wc);
        return max2(max2(ns2cyc(wp, clk_ns), ns2cyc(ds, clk_ns)),
                    max2(ns2cyc(aw, clk_ns), ns2cyc(wc, clk_ns) - 2));
    endfunction

    function automatic int rd_wait_cyc(input int clk_ns, input int aa, input int oe,
                                       input int rc);
        return max2(max2(ns2cyc(aa, clk_ns), ns2cyc(oe, clk_ns)), ns2cyc(rc, clk_ns) - 2);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW   = 3,
    parameter int N_PU = 7,
    parameter int N_RW = 7,
    parameter int N_WL = 6,
    parameter int N_TA = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_last,
    output ctl_state_e    state,
    output logic          accept,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);
    localparam logic [CW-1:0] L_ONE = '0;
    localparam logic [CW-1:0] L_PU  = CW'(N_PU - 1);
    localparam logic [CW-1:0] L_RW  = CW'(N_RW - 1);
    localparam logic [CW-1:0] L_WL  = CW'(N_WL - 1);
    localparam logic [CW-1:0] L_TA  = CW'(N_TA - 1);

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept  = 1'b1;
                state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            end
            ST_RD_SETUP:   if (tmr_last) state_d = ST_RD_WAIT;
            ST_RD_WAIT:    if (tmr_last) state_d = ST_RD_CAPTURE;
            ST_RD_CAPTURE: state_d = ST_TURN;
            ST_WR_SETUP:   if (tmr_last) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    state_d = ST_TURN;
            ST_TURN: if (tmr_last) begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase length of the state being entered; setup is short when the chip stays selected
    always_comb begin
        unique case (state_d)
            ST_RD_SETUP, ST_WR_SETUP: tmr_val = (state_q == ST_TURN) ? L_ONE : L_PU;
            ST_RD_WAIT:               tmr_val = L_RW;
            ST_WR_PULSE:              tmr_val = L_WL;
            ST_TURN:                  tmr_val = L_TA;
            default:                  tmr_val = L_ONE;
        endcase
    end

    assign tmr_load = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_ctl_pkg::*;
(
    input  ctl_state_e state,
    output pin_ctl_t   pins
);
    always_comb begin
        pins = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b1, drive: 1'b0};
        unique case (state)
            ST_IDLE:       pins = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, lanes_on: 1'b0, drive: 1'b0};
            ST_RD_SETUP:   ;
            ST_RD_WAIT:    pins.oe_n = 1'b0;
            ST_RD_CAPTURE: ;
            ST_WR_SETUP:   pins.drive = 1'b1;
            ST_WR_PULSE:   begin pins.we_n = 1'b0; pins.drive = 1'b1; end
            ST_WR_HOLD:    pins.drive = 1'b1;
            ST_TURN:       pins.lanes_on = 1'b0;
            default:       pins.ce_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 50,
    parameter int T_DS_NS   = 30,
    parameter int T_AW_NS   = 60,
    parameter int T_PU_NS   = 70,
    parameter int T_TURN_NS = 10,
    localparam int LANES    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_cs,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_bl_n,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              sram_dq_oe
);
    localparam int N_PU = ns2cyc(T_PU_NS, CLK_NS);
    localparam int N_RW = rd_wait_cyc(CLK_NS, T_AA_NS, T_OE_NS, T_RC_NS);
    localparam int N_WL = wr_pulse_cyc(CLK_NS, T_WP_NS, T_DS_NS, T_AW_NS, T_WC_NS);
    localparam int N_TA = ns2cyc(T_TURN_NS, CLK_NS);
    localparam int N_MX = max2(max2(N_PU, N_RW), max2(N_WL, N_TA));
    localparam int CW   = $clog2(N_MX + 1);

    ctl_state_e        state;
    pin_ctl_t          pins;
    logic              accept, tmr_load, tmr_last;
    logic [CW-1:0]     tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rd_q, lane_mask;
    logic [LANES-1:0]  be_q;

    sram_phase_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_cycle_fsm #(
        .CW(CW), .N_PU(N_PU), .N_RW(N_RW), .N_WL(N_WL), .N_TA(N_TA)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_last  (tmr_last),
        .state     (state),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val)
    );

    sram_pin_decode i_decode (
        .state (state),
        .pins  (pins)
    );

    // Request fields are latched only while write enable is high
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sram_bl_n[i]         = ~(pins.lanes_on & be_q[i]);
        assign lane_mask[i*8 +: 8]  = {8{be_q[i]}};
    end

    // Sample the bus on the final output-enable-low cycle
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (state == ST_RD_WAIT && tmr_last)
            rd_q <= sram_dq & lane_mask;
    end

    assign req_ack    = accept;
    assign rd_data    = rd_q;
    assign rd_valid   = (state == ST_RD_CAPTURE);
    assign sram_addr  = addr_q;
    assign sram_ce_n  = pins.ce_n;
    assign sram_cs    = 1'b1;
    assign sram_oe_n  = pins.oe_n;
    assign sram_we_n  = pins.we_n;
    assign sram_dq_oe = pins.drive;
    assign sram_dq    = pins.drive ? wdata_q : 'z;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int CLK_NS  = 10,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 50,
    parameter int T_DS_NS = 30,
    parameter int T_AW_NS = 60
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);
    localparam int N_WL = wr_pulse_cyc(CLK_NS, T_WP_NS, T_DS_NS, T_AW_NS, T_WC_NS);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)             we_low_cnt <= '0;
        else if (!sram_we_n) we_low_cnt <= we_low_cnt + 1'b1;
        else                 we_low_cnt <= '0;
    end

    assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
        sram_ce_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
        (sram_we_n && we_low_cnt != 0) |-> (we_low_cnt == 16'(N_WL)));

    assert_addr_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_addr));

    assert_we_selected_R4: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n);

    assert_write_strobes_R5: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && sram_dq_oe));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    assert_rdvalid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |=> $stable(sram_addr));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_WC_NS(T_WC_NS),
    .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS), .T_AW_NS(T_AW_NS)
) i_chk (.*);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
    localparam int CLK  = 10;
    localparam int C_PU = (70 + CLK - 1) / CLK;
    localparam int C_RW = 7;
    localparam int C_WL = 6;
    localparam int C_GAP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ack, rd_valid, sram_ce_n, sram_cs, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [15:0] rd_data;
    logic [19:0] sram_addr;
    logic [1:0]  sram_bl_n;
    wire  [15:0] sram_dq;

    int n_chk = 0, n_fail = 0, n_issue = 0, n_ack = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ack(req_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_cs(sram_cs), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bl_n(sram_bl_n),
        .sram_dq(sram_dq), .sram_dq_oe(sram_dq_oe)
    );

    // ---------------- memory model and reference ----------------
    logic [15:0] mem_q [int unsigned];
    logic [15:0] ref_q [int unsigned];
    logic [15:0] m_word = '0;

    function automatic logic [15:0] seed_word(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h3C5};
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return mem_q.exists(int'(a)) ? mem_q[int'(a)] : seed_word(a);
    endfunction

    function automatic logic [15:0] ref_word(input logic [19:0] a);
        return ref_q.exists(int'(a)) ? ref_q[int'(a)] : seed_word(a);
    endfunction

    wire model_drv = !sram_ce_n && sram_cs && !sram_oe_n && sram_we_n && (sram_bl_n != 2'b11);
    assign sram_dq = model_drv ? m_word : 'z;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- pin monitor ----------------
    logic        p_we = 1, p_oe = 1, p_ack = 0;
    logic [19:0] p_addr = '0, addr_fall = '0;
    logic [15:0] p_dq = '0;
    logic [1:0]  p_bl = 2'b11, bl_at_oe = 2'b11;
    int          inact = 0, we_cnt = 0, oe_cnt = 0;
    bit          cold = 1'b1;

    always @(negedge clk) begin
        if (rst) begin
            p_we = 1; p_oe = 1; p_ack = 0; inact = 0; we_cnt = 0; oe_cnt = 0; cold = 1;
        end else begin
            m_word <= mem_word(sram_addr);
            if (req_ack) n_ack++;
            if (req_ack && p_ack) chk(0, "R2 ack longer than one cycle", 2, 1);
            chk(rd_valid == (!p_oe && sram_oe_n), "R7 rd_valid placement", rd_valid, !p_oe && sram_oe_n);
            chk(sram_cs == 1'b1, "R1 chip select", sram_cs, 1);
            if (!sram_we_n) begin
                chk(sram_oe_n && sram_dq_oe, "R5 strobes during write", {sram_oe_n, sram_dq_oe}, 2'b11);
                we_cnt++;
            end
            if (!sram_oe_n) begin
                chk(sram_we_n && !sram_dq_oe, "R6 R5 read strobes", {sram_we_n, sram_dq_oe}, 2'b10);
                oe_cnt++;
            end
            if (sram_ce_n) begin
                chk(sram_bl_n == 2'b11 && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 R10 standby pins",
                    {sram_bl_n, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b11110);
                cold = 1; inact = 0;
            end else if (sram_we_n && sram_oe_n) begin
                inact++;
            end
            if ((p_we && !sram_we_n) || (p_oe && !sram_oe_n)) begin
                if (cold) chk(inact == C_PU, "R3 R10 power-up wait", inact, C_PU);
                else      chk(inact == C_GAP, "R9 back-to-back gap", inact, C_GAP);
                cold = 0; inact = 0; addr_fall = sram_addr;
                if (!sram_oe_n) bl_at_oe = sram_bl_n;
            end
            if (!p_we && sram_we_n) begin
                chk(we_cnt == C_WL, "R4 write pulse width", we_cnt, C_WL);
                chk(p_addr == addr_fall && sram_addr == addr_fall, "R4 R9 address held", sram_addr, addr_fall);
                chk(sram_dq_oe && sram_dq == p_dq, "R4 data held after rise", sram_dq, p_dq);
                mem_q[int'(p_addr)] = (mem_word(p_addr) & ~lane_mask(~p_bl)) | (p_dq & lane_mask(~p_bl));
                we_cnt = 0;
            end
            if (!p_oe && sram_oe_n) begin
                chk(oe_cnt == C_RW, "R6 output-enable width", oe_cnt, C_RW);
                oe_cnt = 0;
            end
            p_we = sram_we_n; p_oe = sram_oe_n; p_ack = req_ack;
            p_addr = sram_addr; p_dq = sram_dq; p_bl = sram_bl_n;
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue(input logic w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        n_issue++;
        forever begin
            #1;
            if (req_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        ref_q[int'(a)] = (ref_word(a) & ~lane_mask(be)) | (d & lane_mask(be));
        issue(1'b1, a, d, be);
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] be, input string tag);
        logic [15:0] exp;
        issue(1'b0, a, 16'h0, be);
        while (!rd_valid) @(negedge clk);
        exp = ref_word(a) & lane_mask(be);
        chk(rd_data == exp, tag, rd_data, exp);
        chk(bl_at_oe == ~be, "R8 lane pins on read", bl_at_oe, ~be);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(sram_ce_n && sram_bl_n == 2'b11 && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid && !req_ack,
            "R1 reset state", {sram_ce_n, sram_bl_n, sram_we_n, sram_oe_n, sram_dq_oe, rd_valid, req_ack}, 8'b11111000);

        // isolated write then read, both from standby
        do_write(20'h12345, 16'hBEEF, 2'b11);
        idle(20);
        do_read(20'h12345, 2'b11, "R7 isolated read");
        idle(5);

        // walking-one addresses, address zero and top address, back-to-back
        for (int i = 0; i <= 21; i++) begin
            logic [19:0] a;
            a = (i == 20) ? 20'h0 : (i == 21) ? 20'hFFFFF : (20'h1 << i);
            do_write(a, 16'(i * 16'h0F0F) ^ 16'h5A17, 2'b11);
        end
        for (int i = 0; i <= 21; i++) begin
            logic [19:0] a;
            a = (i == 20) ? 20'h0 : (i == 21) ? 20'hFFFFF : (20'h1 << i);
            do_read(a, 2'b11, "R12 walking address");
        end
        idle(4);

        // lane-enable sweep on writes and reads (includes both lanes off)
        for (int w = 0; w < 4; w++) begin
            do_write(20'h0ABCD, 16'hC0DE + 16'(w * 16'h1111), 2'(w));
            do_read(20'h0ABCD, 2'b11, "R8 R11 partial write merge");
            for (int r = 0; r < 4; r++)
                do_read(20'h0ABCD, 2'(r), "R8 R11 masked read");
            idle(3);
        end

        // mixed back-to-back write/read pairs
        for (int i = 0; i < 8; i++) begin
            do_write(20'h80000 + 20'(i), 16'hA000 ^ 16'(i * 16'h0123), 2'(i % 4));
            do_read(20'h80000 + 20'(i), 2'b11, "R9 mixed burst");
        end
        idle(4);
        do_read(20'h12345, 2'b11, "R10 read after standby");
        idle(4);
        chk(n_ack == n_issue, "R2 one ack per request", n_ack, n_issue);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule